// File: doc/BRIEF.md
# Dynamic Job Dispatch Unit

This block hands out numbered units of work (jobs 0 through `LAST_JOB`) to `NUM_PROC` processors that share one pool of work. Each processor raises its request line when it is ready for another job and holds it until it receives an answer. The answer is a one-cycle pulse that carries either a job number or an end-of-work indication. Because every answer comes from a single read-and-advance step on internal state, no job number is ever given out twice, even when requests overlap.

Two dispatch disciplines are selected by `stride_mode`. In shared mode, each processor's first job is its own index. Every later job comes from one shared next-job counter that starts at `NUM_PROC` and advances by one per grant, so fast processors take more of the work. In stride mode the work is divided up in advance: processor i receives i, i+`NUM_PROC`, i+2·`NUM_PROC` and so on. A round-robin arbiter serialises requests made in the same cycle, and `done_o` shows when no unassigned job is left.

Top module: `jdu_dispatch`

## Requirements
- R1: While `rst_n` is low, and after its release until the first request is answered, `gnt_o`, `end_o` and every job field of `job_o` are zero and `done_o` is low. The shared counter restarts at `NUM_PROC` and the round-robin pointer restarts so that processor 0 has top priority.
- R2: In shared mode (`stride_mode`=0), the first job answer given to processor i carries job number i.
- R3: In shared mode, every later job answer to any processor carries the value of the shared counter, which advances by exactly one per such answer. Successive shared answers therefore carry `NUM_PROC`, `NUM_PROC`+1, and so on in grant order.
- R4: In stride mode (`stride_mode`=1), processor i receives jobs i, i+`NUM_PROC`, i+2·`NUM_PROC` and so on, in that order, up to `LAST_JOB`.
- R5: A request that finds no job left for its processor is answered by a one-cycle pulse on `end_o[i]`, with `gnt_o[i]` low and job field i zero. Job field i (bits i·JW to i·JW+JW-1 of `job_o`) is zero in every cycle in which `gnt_o[i]` is low.
- R6: At most one answer (`gnt_o` or `end_o` bit) is high in any cycle. An answer appears in the cycle after the clock edge at which the request was sampled high, and it lasts one cycle.
- R7: Among eligible requests, the processor that follows the most recently answered one, in cyclic index order, wins.
- R8: A request line that is high in the same cycle as its own answer is not eligible in that cycle, so one processor never receives answers in two consecutive cycles.
- R9: `done_o` is high exactly when every job of the selected mode has been assigned. It stays high as long as the mode is unchanged.
- R10: Across one run from reset, no job number is given out twice, every job number lies in 0..`LAST_JOB`, and when requests continue every job is eventually given out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stride_mode | input | 1 | 0: shared counter dispatch, 1: fixed stride dispatch; held stable outside reset |
| req_i | input | NUM_PROC | Per-processor request level, held until answered |
| gnt_o | output | NUM_PROC | One-cycle job grant pulse per processor |
| end_o | output | NUM_PROC | One-cycle end-of-work pulse per processor |
| job_o | output | NUM_PROC·JW | Job number for each processor, field i valid with `gnt_o[i]`; JW = ceil(log2(LAST_JOB+2)) |
| done_o | output | 1 | Every job of the current mode has been assigned |

## Verification
The bench holds all request lines high at once so that arbitration runs every cycle. A design that re-granted a processor whose answer was still showing would break the alternation, and a wrong pointer update would reorder the grants. It then checks the shift from first jobs (the processors' indices) to shared-counter jobs, where an off-by-one start value would duplicate job `NUM_PROC`-1 or skip job `NUM_PROC`. It also drives requests well past the last job, where a counter that wrapped instead of saturating would hand out job 0 again rather than end-of-work. Random request patterns in both modes are compared on every cycle against a behavioural model, and each run closes with a check that every job was given out exactly once.

// File: rtl/jdu_pkg.sv
package jdu_pkg;

  typedef enum logic {
    MODE_SHARED = 1'b0,
    MODE_STRIDE = 1'b1
  } dispatch_mode_e;

endpackage

// File: rtl/jdu_rr_arbiter.sv
module jdu_rr_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] elig,
  output logic               pick_vld,
  output logic [IW-1:0]      pick_idx
);

  localparam logic [IW-1:0] PTR_RST = IW'(NUM_REQ - 1);

  logic [IW-1:0] ptr_q;
  logic          ptr_en;

  // search starts one past the last winner and wraps
  always_comb begin
    int cand;
    pick_vld = 1'b0;
    pick_idx = '0;
    cand     = 0;
    for (int off = 1; off <= NUM_REQ; off++) begin
      cand = (int'(ptr_q) + off) % NUM_REQ;
      if (!pick_vld && elig[cand]) begin
        pick_vld = 1'b1;
        pick_idx = IW'(cand);
      end
    end
  end

  assign ptr_en = pick_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= PTR_RST;
    end else if (ptr_en) begin
      ptr_q <= pick_idx;
    end
  end

  assert_pick_is_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> elig[pick_idx]);

  assert_pick_when_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig) |-> pick_vld);

endmodule

// File: rtl/jdu_job_pool.sv
module jdu_job_pool #(
  parameter int NUM_PROC = 4,
  parameter int LAST_JOB = 21,
  localparam int JW = $clog2(LAST_JOB + 2),
  localparam int IW = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stride_mode,
  input  logic          take_vld,
  input  logic [IW-1:0] take_idx,
  output logic [JW-1:0] take_job,
  output logic          take_end,
  output logic          pool_empty
);

  import jdu_pkg::*;

  // value one past the last job marks an exhausted source
  localparam logic [JW-1:0] SENT_W     = JW'(LAST_JOB + 1);
  localparam logic [JW-1:0] SHARED_RST = (NUM_PROC > LAST_JOB) ? SENT_W : JW'(NUM_PROC);

  dispatch_mode_e mode;
  logic [JW-1:0]  own_q [NUM_PROC];
  logic [JW-1:0]  own_sel;
  logic [JW-1:0]  own_nxt;
  logic [NUM_PROC-1:0] own_we;
  logic [JW-1:0]  shared_q;
  logic           shared_we;
  logic           use_own;
  logic [JW-1:0]  src;
  logic           all_own_spent;

  function automatic logic [JW-1:0] stride_step(input logic [JW-1:0] v);
    int s;
    s = int'(v) + NUM_PROC;
    return (s > LAST_JOB) ? SENT_W : JW'(s);
  endfunction

  assign mode = dispatch_mode_e'(stride_mode);

  always_comb begin
    own_sel   = own_q[take_idx];
    use_own   = (mode == MODE_STRIDE) || (own_sel != SENT_W);
    src       = use_own ? own_sel : shared_q;
    take_end  = (src == SENT_W);
    take_job  = take_end ? '0 : src;
    own_nxt   = (mode == MODE_STRIDE) ? stride_step(own_sel) : SENT_W;
    shared_we = take_vld && !take_end && !use_own;
    for (int p = 0; p < NUM_PROC; p++) begin
      own_we[p] = take_vld && !take_end && use_own && (take_idx == IW'(p));
    end
  end

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_own
    localparam logic [JW-1:0] OWN_RST = (g > LAST_JOB) ? SENT_W : JW'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_q[g] <= OWN_RST;
      end else if (own_we[g]) begin
        own_q[g] <= own_nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shared_q <= SHARED_RST;
    end else if (shared_we) begin
      shared_q <= shared_q + JW'(1);
    end
  end

  always_comb begin
    all_own_spent = 1'b1;
    for (int p = 0; p < NUM_PROC; p++) begin
      if (own_q[p] != SENT_W) all_own_spent = 1'b0;
    end
    pool_empty = all_own_spent && ((mode == MODE_STRIDE) || (shared_q == SENT_W));
  end

  assert_shared_steps_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shared_q != $past(shared_q)) |-> (shared_q == $past(shared_q) + JW'(1)));

  assert_stride_residue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vld && !take_end && stride_mode) |-> ((int'(take_job) % NUM_PROC) == int'(take_idx)));

  assert_job_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (take_vld && !take_end) |-> (int'(take_job) <= LAST_JOB));

endmodule

// File: rtl/jdu_dispatch.sv
module jdu_dispatch #(
  parameter int NUM_PROC = 4,
  parameter int LAST_JOB = 21,
  localparam int JW = $clog2(LAST_JOB + 2),
  localparam int IW = (NUM_PROC > 1) ? $clog2(NUM_PROC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   stride_mode,
  input  logic [NUM_PROC-1:0]    req_i,
  output logic [NUM_PROC-1:0]    gnt_o,
  output logic [NUM_PROC-1:0]    end_o,
  output logic [NUM_PROC*JW-1:0] job_o,
  output logic                   done_o
);

  logic [NUM_PROC-1:0] elig;
  logic                pick_vld;
  logic [IW-1:0]       pick_idx;
  logic [JW-1:0]       take_job;
  logic                take_end;
  logic                pool_empty;

  logic [NUM_PROC-1:0] gnt_d, gnt_q;
  logic [NUM_PROC-1:0] end_d, end_q;
  logic [JW-1:0]       job_d [NUM_PROC];
  logic [JW-1:0]       job_q [NUM_PROC];

  // a requester whose answer is on the outputs sits out this cycle
  assign elig = req_i & ~(gnt_q | end_q);

  jdu_rr_arbiter #(.NUM_REQ(NUM_PROC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .elig     (elig),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  jdu_job_pool #(.NUM_PROC(NUM_PROC), .LAST_JOB(LAST_JOB)) u_pool (
    .clk         (clk),
    .rst_n       (rst_n),
    .stride_mode (stride_mode),
    .take_vld    (pick_vld),
    .take_idx    (pick_idx),
    .take_job    (take_job),
    .take_end    (take_end),
    .pool_empty  (pool_empty)
  );

  always_comb begin
    gnt_d = '0;
    end_d = '0;
    for (int p = 0; p < NUM_PROC; p++) begin
      job_d[p] = '0;
      if (pick_vld && (pick_idx == IW'(p))) begin
        gnt_d[p] = !take_end;
        end_d[p] = take_end;
        job_d[p] = take_job;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_q <= '0;
      end_q <= '0;
    end else begin
      gnt_q <= gnt_d;
      end_q <= end_d;
    end
  end

  for (genvar g = 0; g < NUM_PROC; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        job_q[g] <= '0;
      end else begin
        job_q[g] <= job_d[g];
      end
    end

    assign job_o[g*JW +: JW] = job_q[g];

    assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_q[g] || end_q[g]) |=> !(gnt_q[g] || end_q[g]));

    assert_answer_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_q[g] || end_q[g]) |-> $past(req_i[g]));

    assert_idle_field_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_q[g] |-> (job_q[g] == '0));
  end

  assign gnt_o  = gnt_q;
  assign end_o  = end_q;
  assign done_o = pool_empty;

  assert_single_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q | end_q));

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $stable(stride_mode)) |=> done_o);

endmodule

// File: tb/jdu_dispatch_bench.sv
`timescale 1ns/1ps
module jdu_dispatch_bench;

  localparam int K  = 4;
  localparam int N  = 21;
  localparam int JW = $clog2(N + 2);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stride;
  logic [K-1:0]  req;
  logic [K-1:0]  gnt_o, end_o;
  logic [K*JW-1:0] job_o;
  logic          done_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  jdu_dispatch #(.NUM_PROC(K), .LAST_JOB(N)) u_jdu_dispatch (
    .clk (clk), .rst_n (rst_n), .stride_mode (stride), .req_i (req),
    .gnt_o (gnt_o), .end_o (end_o), .job_o (job_o), .done_o (done_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_own [K];
  bit         m_used [K];
  int         m_shared;
  int         m_ptr;
  bit [K-1:0] m_gnt, m_end;
  int         m_job [K];
  bit         m_done;

  always @(posedge clk or negedge rst_n) begin
    bit [K-1:0] busy;
    int pick;
    int c;
    bit all;
    if (!rst_n) begin
      for (int i = 0; i < K; i++) begin
        m_own[i] = i; m_used[i] = 0; m_job[i] = 0;
      end
      m_shared = K; m_ptr = K - 1; m_gnt = '0; m_end = '0; m_done = 0;
    end else begin
      busy  = m_gnt | m_end;
      m_gnt = '0; m_end = '0;
      for (int i = 0; i < K; i++) m_job[i] = 0;
      pick = -1;
      for (int off = 1; off <= K; off++) begin
        c = (m_ptr + off) % K;
        if (pick < 0 && req[c] && !busy[c]) pick = c;
      end
      if (pick >= 0) begin
        m_ptr = pick;
        if (stride) begin
          if (m_own[pick] <= N) begin
            m_gnt[pick] = 1; m_job[pick] = m_own[pick]; m_own[pick] += K;
          end else m_end[pick] = 1;
        end else begin
          if (!m_used[pick] && pick <= N) begin
            m_used[pick] = 1; m_gnt[pick] = 1; m_job[pick] = pick;
          end else if (m_shared <= N) begin
            m_gnt[pick] = 1; m_job[pick] = m_shared; m_shared++;
          end else m_end[pick] = 1;
        end
      end
      all = 1;
      for (int i = 0; i < K; i++) begin
        if (stride) begin
          if (m_own[i] <= N) all = 0;
        end else if (!m_used[i] && i <= N) all = 0;
      end
      m_done = all && (stride || m_shared > N);
    end
  end

  // ---------------- per-cycle compare and request driving ----------------
  bit         cmp_en = 0;
  int         scen   = 0;       // 0 idle, 1 all held high, 2 pseudo-random
  bit         seen [N+1];
  bit [K-1:0] prev_busy = '0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    int act_j;
    string tag;
    if (cmp_en) begin
      check(gnt_o == m_gnt, "R7", "grant vector", int'(gnt_o), int'(m_gnt));
      check(end_o == m_end, "R5", "end vector", int'(end_o), int'(m_end));
      check(done_o == m_done, "R9", "done", int'(done_o), int'(m_done));
      check($countones(gnt_o | end_o) <= 1, "R6", "answers this cycle",
            $countones(gnt_o | end_o), 1);
      for (int i = 0; i < K; i++) begin
        act_j = int'(job_o[i*JW +: JW]);
        if (stride) tag = "R4";
        else if (m_gnt[i] && m_job[i] < K) tag = "R2";
        else if (m_gnt[i]) tag = "R3";
        else tag = "R5";
        check(act_j == m_job[i], tag, $sformatf("job field %0d", i), act_j, m_job[i]);
        if (prev_busy[i])
          check(!(gnt_o[i] || end_o[i]), "R8", $sformatf("repeat answer proc %0d", i),
                int'(gnt_o[i] || end_o[i]), 0);
        if (gnt_o[i]) begin
          if (act_j <= N) begin
            check(!seen[act_j], "R10", "duplicate job", act_j, -1);
            seen[act_j] = 1;
          end else check(0, "R10", "job out of range", act_j, N);
        end
      end
      prev_busy = gnt_o | end_o;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (scen == 1) req = '1;
    else if (scen == 2) begin
      for (int i = 0; i < K; i++) begin
        if (gnt_o[i] || end_o[i]) req[i] = lfsr[i] & lfsr[i+4];
        else if (!req[i]) req[i] = lfsr[i+8];
      end
    end else req = '0;
  end

  task automatic do_reset(input bit mode);
    cmp_en = 0; scen = 0;
    @(negedge clk);
    rst_n  = 1'b0;
    stride = mode;
    for (int j = 0; j <= N; j++) seen[j] = 0;
    prev_busy = '0;
    repeat (2) @(negedge clk);
    // R1: idle outputs while held in reset
    check(gnt_o == '0 && end_o == '0, "R1", "answers in reset", int'(gnt_o | end_o), 0);
    check(job_o == '0, "R1", "job bus in reset", int'(job_o != '0), 0);
    check(done_o == 1'b0, "R1", "done in reset", int'(done_o), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: still idle after release with no request seen
    check(gnt_o == '0 && end_o == '0 && !done_o, "R1", "idle after release",
          int'(gnt_o | end_o) + int'(done_o), 0);
    cmp_en = 1;
  endtask

  task automatic run_scen(input int s, input int cycles);
    scen = s;
    repeat (cycles) @(negedge clk);
    scen = 0;
    repeat (4) @(negedge clk);
    // R10: every job handed out; R9: done reported
    for (int j = 0; j <= N; j++)
      check(seen[j], "R10", $sformatf("job %0d never given", j), int'(seen[j]), 1);
    check(done_o == 1'b1, "R9", "done at end of run", int'(done_o), 1);
  endtask

  initial begin
    rst_n  = 1'b0;
    stride = 1'b0;
    req    = '0;
    do_reset(1'b0); run_scen(1, 80);
    do_reset(1'b0); run_scen(2, 160);
    do_reset(1'b1); run_scen(1, 80);
    do_reset(1'b1); run_scen(2, 160);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule